// File: doc/BRIEF.md
# Banked Data Memory Address Decoder

This block sits between a small processor core and its data memory. Every data access arrives as a 7-bit in-bank offset and a 2-bit bank number. The offset and bank come either from the instruction, which is the direct form, or from a 9-bit pointer register, which is the indirect form. The block sorts each access into one of four regions:
- the special-function-register window, passed to an external register block through a select/strobe interface;
- 48 bytes of general-purpose RAM that exist only in bank 0;
- a 16-byte common window that every bank sees as the same storage;
- unimplemented space.

Reads are combinational from the decoded address. Writes land on the rising clock edge. Unimplemented space reads as zero and discards writes. The core uses this block as its single data-memory port. The special-function registers themselves, and the ALU, live outside the block.

Top module: `bank_data_mem_decoder`

## Requirements
- R1: With `ind_sel` low, the bank comes from `dir_bank`: 2'b00 selects bank 0, 2'b01 bank 1, 2'b10 bank 2 and 2'b11 bank 3. `sfr_bank` shows the selected bank.
- R2: Offsets 00h-1Fh in any bank address the special-function-register window. For these offsets, `sfr_sel` is high, `sfr_addr` carries offset bits [4:0] and `sfr_wdata` follows `wr_data`. `sfr_rd` equals `rd_en` and `sfr_wr` equals `wr_en`, and `rd_data` returns `sfr_rdata` while `rd_en` is high. For any other offset, `sfr_sel`, `sfr_rd` and `sfr_wr` are low.
- R3: Offsets 40h-6Fh in bank 0 are 48 RAM bytes. A write is stored on the rising edge while `wr_en` is high, and a read returns the stored byte in the same cycle.
- R4: Offsets 70h-7Fh address 16 common bytes that are the same storage in all four banks.
- R5: Offsets 20h-3Fh in any bank, and offsets 40h-6Fh in banks 1-3, read as 00h.
- R6: A write to an unimplemented location changes no RAM byte.
- R7: With `ind_sel` high, the offset is `ind_ptr[6:0]` and the bank is `ind_ptr[8:7]`, and `dir_addr`/`dir_bank` are not used.
- R8: While `rd_en` is low, `rd_data` is 00h and `sfr_rd` is low.
- R9: While `rst_n` is low, every RAM byte is cleared to 00h.
- R10: In one cycle, at most one of the targets (general RAM, common RAM, special-function window) receives a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_addr | input | 7 | Direct in-bank offset |
| dir_bank | input | 2 | Direct bank select |
| ind_sel | input | 1 | 1 = take offset and bank from `ind_ptr` |
| ind_ptr | input | 9 | Indirect pointer: bank in [8:7], offset in [6:0] |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| sfr_rdata | input | 8 | Read data returned by the external register block |
| sfr_sel | output | 1 | Access falls in the special-function window |
| sfr_bank | output | 2 | Effective bank toward the register block |
| sfr_addr | output | 5 | Offset within the special-function window |
| sfr_rd | output | 1 | Read strobe toward the register block |
| sfr_wr | output | 1 | Write strobe toward the register block |
| sfr_wdata | output | 8 | Write data toward the register block |

## Verification
Each region is probed with a write followed by reads that use the same offset under different banks.

- The same RAM offset is written in bank 0 and bank 1. Reading it back separates the bank-0-only general RAM from a wrongly mirrored one.
- Common bytes are written in one bank and read in all the others, which shows the mirror is real.
- Writes to 20h-3Fh and to banked-out 40h-6Fh are followed by reads of the bank-0 alias, which exposes a write that leaked into storage.
- Indirect accesses set a pointer bank that differs from `dir_bank`, so a decoder that takes the wrong bank source reads or writes the wrong place.

// File: rtl/bank_mem_pkg.sv
`timescale 1ns/1ps
package bank_mem_pkg;
    localparam int ADDR_W    = 7;
    localparam int BANK_W    = 2;
    localparam int DATA_W    = 8;
    localparam int SFR_SPAN  = 32;
    localparam int GPR_BASE  = 'h40;
    localparam int GPR_N     = 48;
    localparam int COM_BASE  = 'h70;
    localparam int COM_N     = 16;
    localparam int GPR_BANK  = 0;

    typedef enum logic [1:0] {
        RGN_SFR    = 2'd0,
        RGN_GPR    = 2'd1,
        RGN_COMMON = 2'd2,
        RGN_NONE   = 2'd3
    } region_e;
endpackage

// File: rtl/bank_addr_decode.sv
`timescale 1ns/1ps
module bank_addr_decode
    import bank_mem_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BANK_W,
    localparam int SFR_AW = $clog2(SFR_SPAN),
    localparam int GPR_IW = $clog2(GPR_N),
    localparam int COM_IW = $clog2(COM_N)
) (
    input  logic [AW-1:0]    dir_addr,
    input  logic [BW-1:0]    dir_bank,
    input  logic             ind_sel,
    input  logic [AW+BW-1:0] ind_ptr,
    output region_e          region,
    output logic [BW-1:0]    eff_bank,
    output logic [SFR_AW-1:0] sfr_off,
    output logic [GPR_IW-1:0] gpr_idx,
    output logic [COM_IW-1:0] com_idx
);
    localparam logic [AW-1:0] SFR_END_A = AW'(SFR_SPAN - 1);
    localparam logic [AW-1:0] GPR_LO_A  = AW'(GPR_BASE);
    localparam logic [AW-1:0] GPR_HI_A  = AW'(GPR_BASE + GPR_N - 1);
    localparam logic [AW-1:0] COM_LO_A  = AW'(COM_BASE);
    localparam logic [AW-1:0] COM_HI_A  = AW'(COM_BASE + COM_N - 1);
    localparam logic [BW-1:0] GPR_BK_B  = BW'(GPR_BANK);

    logic [AW-1:0] eff_addr;

    // Source select: pointer fields or instruction fields
    always_comb begin
        if (ind_sel) begin
            eff_addr = ind_ptr[AW-1:0];
            eff_bank = ind_ptr[AW+BW-1:AW];
        end else begin
            eff_addr = dir_addr;
            eff_bank = dir_bank;
        end
    end

    // Region classification
    always_comb begin
        region = RGN_NONE;
        if (eff_addr <= SFR_END_A)
            region = RGN_SFR;
        else if (eff_addr >= COM_LO_A && eff_addr <= COM_HI_A)
            region = RGN_COMMON;
        else if (eff_addr >= GPR_LO_A && eff_addr <= GPR_HI_A && eff_bank == GPR_BK_B)
            region = RGN_GPR;
    end

    always_comb begin
        sfr_off = SFR_AW'(eff_addr);
        gpr_idx = GPR_IW'(eff_addr - GPR_LO_A);
        com_idx = COM_IW'(eff_addr - COM_LO_A);
    end
endmodule

// File: rtl/bank_ram_store.sv
`timescale 1ns/1ps
module bank_ram_store
    import bank_mem_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NG = GPR_N,
    parameter int NC = COM_N,
    localparam int GPR_IW = $clog2(NG),
    localparam int COM_IW = $clog2(NC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gpr_we,
    input  logic [GPR_IW-1:0] gpr_idx,
    input  logic              com_we,
    input  logic [COM_IW-1:0] com_idx,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     gpr_q,
    output logic [DW-1:0]     com_q
);
    logic [NG-1:0][DW-1:0] gpr_mem;
    logic [NC-1:0][DW-1:0] com_mem;

    for (genvar g = 0; g < NG; g++) begin : g_gpr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                gpr_mem[g] <= '0;
            else if (gpr_we && gpr_idx == GPR_IW'(g))
                gpr_mem[g] <= wdata;
        end
    end

    for (genvar c = 0; c < NC; c++) begin : g_com
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                com_mem[c] <= '0;
            else if (com_we && com_idx == COM_IW'(c))
                com_mem[c] <= wdata;
        end
    end

    always_comb begin
        gpr_q = (32'(gpr_idx) < NG) ? gpr_mem[gpr_idx] : '0;
        com_q = com_mem[com_idx];
    end

    // R6
    gpr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gpr_we |=> $stable(gpr_mem));

    // R6
    com_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !com_we |=> $stable(com_mem));
endmodule

// File: rtl/bank_data_mem_decoder.sv
`timescale 1ns/1ps
module bank_data_mem_decoder
    import bank_mem_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BANK_W,
    parameter int DW = DATA_W,
    localparam int SFR_AW = $clog2(SFR_SPAN),
    localparam int GPR_IW = $clog2(GPR_N),
    localparam int COM_IW = $clog2(COM_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    dir_addr,
    input  logic [BW-1:0]    dir_bank,
    input  logic             ind_sel,
    input  logic [AW+BW-1:0] ind_ptr,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_data,
    input  logic [DW-1:0]    sfr_rdata,
    output logic             sfr_sel,
    output logic [BW-1:0]    sfr_bank,
    output logic [SFR_AW-1:0] sfr_addr,
    output logic             sfr_rd,
    output logic             sfr_wr,
    output logic [DW-1:0]    sfr_wdata
);
    region_e           region;
    logic [BW-1:0]     eff_bank;
    logic [SFR_AW-1:0] sfr_off;
    logic [GPR_IW-1:0] gpr_idx;
    logic [COM_IW-1:0] com_idx;
    logic              gpr_we, com_we;
    logic [DW-1:0]     gpr_q, com_q;

    bank_addr_decode #(.AW(AW), .BW(BW)) u_decode (
        .dir_addr (dir_addr),
        .dir_bank (dir_bank),
        .ind_sel  (ind_sel),
        .ind_ptr  (ind_ptr),
        .region   (region),
        .eff_bank (eff_bank),
        .sfr_off  (sfr_off),
        .gpr_idx  (gpr_idx),
        .com_idx  (com_idx)
    );

    always_comb begin
        gpr_we = wr_en && (region == RGN_GPR);
        com_we = wr_en && (region == RGN_COMMON);
    end

    bank_ram_store #(.DW(DW), .NG(GPR_N), .NC(COM_N)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .gpr_we  (gpr_we),
        .gpr_idx (gpr_idx),
        .com_we  (com_we),
        .com_idx (com_idx),
        .wdata   (wr_data),
        .gpr_q   (gpr_q),
        .com_q   (com_q)
    );

    // Register-block interface
    always_comb begin
        sfr_sel   = (region == RGN_SFR);
        sfr_bank  = eff_bank;
        sfr_addr  = sfr_off;
        sfr_rd    = sfr_sel && rd_en;
        sfr_wr    = sfr_sel && wr_en;
        sfr_wdata = wr_data;
    end

    // Read return mux
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (region)
                RGN_SFR:    rd_data = sfr_rdata;
                RGN_GPR:    rd_data = gpr_q;
                RGN_COMMON: rd_data = com_q;
                RGN_NONE:   rd_data = '0;
            endcase
        end
    end

    // R4
    common_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && region == RGN_COMMON && $past(rst_n) && $past(com_we)
         && $past(com_idx) == com_idx) |-> rd_data == $past(wr_data));

    // R5
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && region == RGN_NONE) |-> rd_data == '0);

    // R8
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0 && !sfr_rd));

    // R10
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gpr_we, com_we, sfr_wr}));
endmodule

// File: tb/bank_data_mem_decoder_bench.sv
`timescale 1ns/1ps
module bank_data_mem_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] dir_addr = '0;
    logic [1:0] dir_bank = '0;
    logic       ind_sel = 1'b0;
    logic [8:0] ind_ptr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] sfr_rdata;
    logic       sfr_sel;
    logic [1:0] sfr_bank;
    logic [4:0] sfr_addr;
    logic       sfr_rd, sfr_wr;
    logic [7:0] sfr_wdata;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // Register block model: returns a pattern built from bank and offset
    assign sfr_rdata = {sfr_bank, 1'b1, sfr_addr};

    bank_data_mem_decoder u_bank_data_mem_decoder (
        .clk(clk), .rst_n(rst_n), .dir_addr(dir_addr), .dir_bank(dir_bank),
        .ind_sel(ind_sel), .ind_ptr(ind_ptr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .sfr_rdata(sfr_rdata),
        .sfr_sel(sfr_sel), .sfr_bank(sfr_bank), .sfr_addr(sfr_addr),
        .sfr_rd(sfr_rd), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic aim(input bit ind, input logic [1:0] bk, input logic [6:0] a);
        ind_sel = ind;
        if (ind) begin
            ind_ptr  = {bk, a};
            dir_bank = ~bk;
            dir_addr = a ^ 7'h11;
        end else begin
            dir_bank = bk;
            dir_addr = a;
            ind_ptr  = {~bk, a ^ 7'h22};
        end
    endtask

    task automatic wr(input bit ind, input logic [1:0] bk, input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        aim(ind, bk, a);
        rd_en = 1'b0; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input bit ind, input logic [1:0] bk, input logic [6:0] a, output logic [7:0] q);
        @(negedge clk);
        aim(ind, bk, a);
        wr_en = 1'b0; rd_en = 1'b1;
        #1 q = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] q;
        rd(0, 2'd0, 7'h40, q); chk("R9 gpr 40h after reset", q, 8'h00);
        rd(0, 2'd0, 7'h6F, q); chk("R9 gpr 6Fh after reset", q, 8'h00);
        rd(0, 2'd1, 7'h70, q); chk("R9 common 70h after reset", q, 8'h00);
        rd(0, 2'd3, 7'h7F, q); chk("R9 common 7Fh after reset", q, 8'h00);
    endtask

    task automatic t_gpr();
        logic [7:0] q;
        wr(0, 2'd0, 7'h40, 8'h11);
        wr(0, 2'd0, 7'h55, 8'h5A);
        wr(0, 2'd0, 7'h6F, 8'hF0);
        rd(0, 2'd0, 7'h40, q); chk("R3 gpr 40h", q, 8'h11);
        rd(0, 2'd0, 7'h55, q); chk("R3 gpr 55h", q, 8'h5A);
        rd(0, 2'd0, 7'h6F, q); chk("R3 gpr 6Fh", q, 8'hF0);
        chk("R2 sfr_sel low on gpr", {7'd0, sfr_sel}, 8'h00);
    endtask

    task automatic t_common();
        logic [7:0] q;
        wr(0, 2'd2, 7'h73, 8'hC3);
        rd(0, 2'd0, 7'h73, q); chk("R4 common 73h bank0", q, 8'hC3);
        rd(0, 2'd1, 7'h73, q); chk("R4 common 73h bank1", q, 8'hC3);
        rd(0, 2'd3, 7'h73, q); chk("R4 common 73h bank3", q, 8'hC3);
        wr(0, 2'd3, 7'h7F, 8'h3C);
        rd(0, 2'd0, 7'h7F, q); chk("R4 common 7Fh bank0", q, 8'h3C);
        rd(0, 2'd0, 7'h73, q); chk("R4 neighbour kept", q, 8'hC3);
    endtask

    task automatic t_unimpl();
        logic [7:0] q;
        rd(0, 2'd1, 7'h40, q); chk("R1 bank1 40h not bank0", q, 8'h00);
        wr(0, 2'd1, 7'h55, 8'hEE);
        rd(0, 2'd1, 7'h55, q); chk("R5 bank1 55h reads zero", q, 8'h00);
        rd(0, 2'd0, 7'h55, q); chk("R6 bank0 55h unchanged", q, 8'h5A);
        wr(0, 2'd0, 7'h30, 8'h77);
        rd(0, 2'd0, 7'h30, q); chk("R5 bank0 30h reads zero", q, 8'h00);
        rd(0, 2'd2, 7'h20, q); chk("R5 bank2 20h reads zero", q, 8'h00);
        rd(0, 2'd3, 7'h6F, q); chk("R5 bank3 6Fh reads zero", q, 8'h00);
        rd(0, 2'd0, 7'h40, q); chk("R6 bank0 40h unchanged", q, 8'h11);
        rd(0, 2'd0, 7'h70, q); chk("R6 common 70h unchanged", q, 8'h00);
    endtask

    task automatic t_sfr();
        logic [7:0] q;
        rd(0, 2'd2, 7'h05, q); chk("R2 sfr read bank2 05h", q, 8'hA5);
        chk("R2 sfr_sel/sfr_rd", {6'd0, sfr_sel, sfr_rd}, 8'h03);
        rd(0, 2'd3, 7'h1F, q); chk("R1 sfr read bank3 1Fh", q, 8'hFF);
        chk("R1 sfr_bank", {6'd0, sfr_bank}, 8'h03);
        @(negedge clk);
        aim(0, 2'd1, 7'h0A);
        rd_en = 1'b0; wr_en = 1'b1; wr_data = 8'h42;
        #1;
        chk("R2 sfr_wr strobe", {7'd0, sfr_wr}, 8'h01);
        chk("R2 sfr_addr", {3'd0, sfr_addr}, 8'h0A);
        chk("R2 sfr_wdata", sfr_wdata, 8'h42);
        chk("R1 sfr_bank bank1", {6'd0, sfr_bank}, 8'h01);
        @(negedge clk);
        wr_en = 1'b0;
        aim(0, 2'd0, 7'h40);
        wr_en = 1'b1;
        #1 chk("R2 sfr_wr low outside window", {7'd0, sfr_wr}, 8'h00);
        wr_en = 1'b0; wr_data = 8'h11;
    endtask

    task automatic t_indirect();
        logic [7:0] q;
        wr(1, 2'd0, 7'h60, 8'h99);
        rd(0, 2'd0, 7'h60, q); chk("R7 indirect write lands bank0", q, 8'h99);
        rd(1, 2'd0, 7'h60, q); chk("R7 indirect read bank0", q, 8'h99);
        rd(1, 2'd2, 7'h60, q); chk("R7 indirect bank2 reads zero", q, 8'h00);
        rd(1, 2'd1, 7'h1C, q); chk("R7 indirect sfr bank1", q, 8'h7C);
        rd(1, 2'd3, 7'h7F, q); chk("R7 indirect common", q, 8'h3C);
    endtask

    task automatic t_idle();
        @(negedge clk);
        aim(0, 2'd0, 7'h40);
        rd_en = 1'b0; wr_en = 1'b0;
        #1 chk("R8 rd_data zero when idle", rd_data, 8'h00);
        aim(0, 2'd0, 7'h04);
        #1 chk("R8 sfr_rd low when idle", {7'd0, sfr_rd}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gpr();
        t_common();
        t_unimpl();
        t_sfr();
        t_indirect();
        t_idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, got=timeout exp=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule